// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block reads one page from an 8-bit NAND flash device. A host request supplies a row (page) number and a byte count. The sequencer then drives the command, address and read-strobe cycles on the flash bus, one bus operation per clock. Bus-level setup and hold timing is left to a wrapper. Every byte read from the main area is forwarded on a byte stream.

When the byte count is a nonzero whole number of sectors, the sequencer gates an external ECC engine on for each sector and pulses a capture strobe once the sector has been read. It keeps each captured value. It then moves the read column into the spare area, fetches the ECC word stored there for each sector, and presents the captured word and the stored word side by side. Correcting the data is left to the consumer. Every request ends by polling the device status until the ready bit is set. A cycle budget bounds this poll, and a timeout flag reports when the budget runs out.

Top module: `nand_page_rd`

## Requirements
- R1: After reset the block is idle. busy_o=0, req_ready_o=1, and the CLE, ALE, RE, ECC enable, capture, byte_valid, sec_valid and done outputs are all 0.
- R2: An accepted request with nonzero length first issues command 0x00 (CLE with WE). It then issues five address cycles (ALE with WE): 0x00, 0x00, row[7:0], row[15:8], row[23:16]. Command 0x30 follows. Each cycle takes one clock.
- R3: After the 0x30 command, the block waits RD_DLY idle cycles before its first read strobe. It waits the same RD_DLY cycles after the 0xE0 command.
- R4: Each main-area byte is sampled in a cycle with nand_re_o=1. It appears on byte_o with byte_valid_o=1 in the following cycle, in read order, with exactly req_len_i bytes.
- R5: ECC mode applies when req_len_i is nonzero and a multiple of SECT_BYTES. In this mode ecc_en_o is high on exactly the SECT_BYTES read cycles of each sector. The cycle after a sector's last read is a capture cycle with ecc_cap_o=1, ecc_en_o=0 and no bus strobe. ecc_val_i is stored for that sector in the capture cycle.
- R6: Raw mode applies when req_len_i is nonzero and not a multiple of SECT_BYTES. In this mode the block reads req_len_i bytes with ecc_en_o and ecc_cap_o held low. It skips the column change, emits no sector result, and goes straight to status polling.
- R7: After the last capture in ECC mode, the block issues command 0x05 and then two address cycles holding PAGE_BYTES+16, low byte first. Command 0xE0 follows, then the R3 wait, then 4 reads per sector.
- R8: Stored ECC words are little-endian, with the first spare byte in bits 7:0. One cycle after the 4th byte of sector k is read, sec_valid_o=1 with sec_idx_o=k, sec_calc_o set to the value captured for k, and sec_stored_o set to the assembled word.
- R9: Each status poll is command 0x70, then TWHR_DLY idle cycles, then one read. If bit 6 of the read byte is 1, the next cycle has done_o=1 and timeout_o=0 and the block is idle. The other status bits are ignored. If bit 6 is 0, the poll repeats.
- R10: The status-phase cycle count starts at 0 in the first 0x70 cycle and rises by one every cycle. A poll that reads bit 6 as 0 while this count is at least TMO_CYC ends the request, with done_o=1 and timeout_o=1. timeout_o holds until the next accepted request.
- R11: A request with req_len_i=0 skips the read and goes directly to status polling.
- R12: While busy_o=1, req_valid_i is ignored and the bus sequence is unchanged. After done_o, no bus cycle occurs until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_page_i | input | ROW_W | Row (page) number |
| req_len_i | input | clog2(PAGE_BYTES+1) | Bytes to read from the main area |
| req_ready_o | output | 1 | High when a request can be taken |
| busy_o | output | 1 | Request in progress |
| nand_cle_o | output | 1 | Command latch cycle |
| nand_ale_o | output | 1 | Address latch cycle |
| nand_we_o | output | 1 | Write strobe for command and address cycles |
| nand_re_o | output | 1 | Read strobe; nand_dq_i is sampled at the clock edge ending the cycle |
| nand_dq_o | output | 8 | Command or address byte |
| nand_dq_i | input | 8 | Byte from the device |
| ecc_en_o | output | 1 | ECC engine enable |
| ecc_cap_o | output | 1 | ECC capture strobe |
| ecc_val_i | input | 32 | ECC engine result |
| byte_valid_o | output | 1 | byte_o is valid |
| byte_o | output | 8 | Main-area byte |
| sec_valid_o | output | 1 | Sector ECC pair is valid |
| sec_idx_o | output | clog2(PAGE_BYTES/SECT_BYTES) | Sector index |
| sec_calc_o | output | 32 | ECC captured from the engine |
| sec_stored_o | output | 32 | ECC read from the spare area |
| done_o | output | 1 | One-cycle end-of-request pulse |
| timeout_o | output | 1 | Last request ended without ready |

## Verification
In ECC mode, each capture pulse shares its cycle with the byte stream output of that sector's last byte. The pair emission for the last sector shares its cycle with the first status command. The bench runs one-sector, multi-sector and full-page reads with a bench-side ECC engine that sums the gated bytes. On every capture cycle it requires byte_valid_o to be high. It compares the full cycle-by-cycle bus trace and the sector pairs against sequences computed from the row number and the length, so a capture that is taken a cycle early or late, or a pair that is dropped, shows up as a mismatch.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam logic [7:0] OP_RD_SETUP  = 8'h00;
  localparam logic [7:0] OP_RD_CONF   = 8'h30;
  localparam logic [7:0] OP_COL_SETUP = 8'h05;
  localparam logic [7:0] OP_COL_CONF  = 8'hE0;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam int unsigned RDY_BIT     = 6;
  localparam int unsigned SPARE_OFS   = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_RD, S_ADDR, S_CMD_CONF, S_WAIT_RD, S_DATA, S_ECC_CAP,
    S_CMD_COL, S_COL, S_CMD_COLC, S_WAIT_COL, S_SPARE,
    S_STAT_CMD, S_STAT_WAIT, S_STAT_RD
  } rd_state_e;
endpackage

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl
  import nand_rd_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned ROW_W      = 24,
  parameter int unsigned RD_DLY     = 10,
  parameter int unsigned TWHR_DLY   = 6,
  parameter int unsigned TMO_CYC    = 100000,
  parameter int unsigned LEN_W      = 13,
  parameter int unsigned NSEC       = 8,
  parameter int unsigned IDX_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ROW_W-1:0] req_page_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  output logic             busy_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_o,
  output logic             re_o,
  output logic [7:0]       dq_o,
  input  logic [7:0]       dq_i,
  output logic             ecc_en_o,
  output logic             ecc_cap_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             spare_rd_o,
  output logic [1:0]       spare_lane_o,
  output logic [IDX_W-1:0] spare_idx_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int unsigned SW     = $clog2(SECT_BYTES);
  localparam int unsigned SEC_W  = $clog2(NSEC + 1);
  localparam int unsigned DMAX   = (RD_DLY > TWHR_DLY) ? RD_DLY : TWHR_DLY;
  localparam int unsigned DLY_W  = $clog2(DMAX + 1);
  localparam int unsigned TMO_W  = $clog2(TMO_CYC + 1);
  localparam logic [15:0] SPARE_COL = 16'(PAGE_BYTES + SPARE_OFS);

  rd_state_e        state_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic [SEC_W-1:0] sec_q, nsec_q;
  logic [DLY_W-1:0] dly_q;
  logic [TMO_W-1:0] tmo_q;
  logic [ROW_W-1:0] page_q;
  logic             ecc_q, bv_q, done_q, tmo_flag_q;
  logic [7:0]       byte_q;
  logic [23:0]      row24;
  logic [LEN_W-1:0] spare_last;
  logic             stat_ph;

  assign row24      = 24'(page_q);
  assign spare_last = LEN_W'({nsec_q, 2'b00}) - LEN_W'(1);
  assign stat_ph    = state_q inside {S_STAT_CMD, S_STAT_WAIT, S_STAT_RD};

  always_comb begin
    dq_o = 8'h00;
    unique case (state_q)
      S_CMD_RD:   dq_o = OP_RD_SETUP;
      S_ADDR: begin
        if (idx_q == LEN_W'(2)) dq_o = row24[7:0];
        if (idx_q == LEN_W'(3)) dq_o = row24[15:8];
        if (idx_q == LEN_W'(4)) dq_o = row24[23:16];
      end
      S_CMD_CONF: dq_o = OP_RD_CONF;
      S_CMD_COL:  dq_o = OP_COL_SETUP;
      S_COL:      dq_o = (idx_q == '0) ? SPARE_COL[7:0] : SPARE_COL[15:8];
      S_CMD_COLC: dq_o = OP_COL_CONF;
      S_STAT_CMD: dq_o = OP_STATUS;
      default:    dq_o = 8'h00;
    endcase
  end

  assign cle_o        = state_q inside {S_CMD_RD, S_CMD_CONF, S_CMD_COL, S_CMD_COLC, S_STAT_CMD};
  assign ale_o        = state_q inside {S_ADDR, S_COL};
  assign we_o         = cle_o | ale_o;
  assign re_o         = state_q inside {S_DATA, S_SPARE, S_STAT_RD};
  assign ecc_en_o     = (state_q == S_DATA) && ecc_q;
  assign ecc_cap_o    = (state_q == S_ECC_CAP);
  assign cap_idx_o    = IDX_W'(sec_q);
  assign spare_rd_o   = (state_q == S_SPARE);
  assign spare_lane_o = idx_q[1:0];
  assign spare_idx_o  = IDX_W'(idx_q >> 2);
  assign busy_o       = (state_q != S_IDLE);
  assign req_ready_o  = (state_q == S_IDLE);
  assign byte_valid_o = bv_q;
  assign byte_o       = byte_q;
  assign done_o       = done_q;
  assign timeout_o    = tmo_flag_q;

  // status-phase cycle budget
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmo_q <= '0;
    else if (!stat_ph)      tmo_q <= '0;
    else if (tmo_q != '1)   tmo_q <= tmo_q + TMO_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  idx_q <= '0;  len_q <= '0;  sec_q <= '0;  nsec_q <= '0;
      dly_q <= '0;  page_q <= '0;  ecc_q <= 1'b0;  bv_q <= 1'b0;  byte_q <= '0;
      done_q <= 1'b0;  tmo_flag_q <= 1'b0;
    end else begin
      bv_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          page_q     <= req_page_i;
          len_q      <= req_len_i;
          ecc_q      <= (req_len_i != '0) && (req_len_i[SW-1:0] == '0);
          nsec_q     <= SEC_W'(req_len_i >> SW);
          idx_q      <= '0;
          sec_q      <= '0;
          tmo_flag_q <= 1'b0;
          state_q    <= (req_len_i == '0) ? S_STAT_CMD : S_CMD_RD;
        end
        S_CMD_RD: begin idx_q <= '0; state_q <= S_ADDR; end
        S_ADDR: begin
          idx_q <= (idx_q == LEN_W'(4)) ? '0 : idx_q + LEN_W'(1);
          if (idx_q == LEN_W'(4)) state_q <= S_CMD_CONF;
        end
        S_CMD_CONF: begin dly_q <= '0; state_q <= S_WAIT_RD; end
        S_WAIT_RD, S_WAIT_COL: begin
          dly_q <= dly_q + DLY_W'(1);
          if (dly_q == DLY_W'(RD_DLY - 1)) begin
            idx_q   <= '0;
            state_q <= (state_q == S_WAIT_RD) ? S_DATA : S_SPARE;
          end
        end
        S_DATA: begin
          bv_q   <= 1'b1;
          byte_q <= dq_i;
          idx_q  <= idx_q + LEN_W'(1);
          if (ecc_q && idx_q == LEN_W'(SECT_BYTES - 1)) begin
            idx_q   <= '0;
            state_q <= S_ECC_CAP;
          end else if (!ecc_q && idx_q == len_q - LEN_W'(1)) begin
            state_q <= S_STAT_CMD;
          end
        end
        S_ECC_CAP: begin
          sec_q   <= sec_q + SEC_W'(1);
          state_q <= (sec_q + SEC_W'(1) == nsec_q) ? S_CMD_COL : S_DATA;
        end
        S_CMD_COL: begin idx_q <= '0; state_q <= S_COL; end
        S_COL: begin
          idx_q <= idx_q + LEN_W'(1);
          if (idx_q == LEN_W'(1)) state_q <= S_CMD_COLC;
        end
        S_CMD_COLC: begin dly_q <= '0; state_q <= S_WAIT_COL; end
        S_SPARE: begin
          idx_q <= idx_q + LEN_W'(1);
          if (idx_q == spare_last) state_q <= S_STAT_CMD;
        end
        S_STAT_CMD: begin dly_q <= '0; state_q <= S_STAT_WAIT; end
        S_STAT_WAIT: begin
          dly_q <= dly_q + DLY_W'(1);
          if (dly_q == DLY_W'(TWHR_DLY - 1)) state_q <= S_STAT_RD;
        end
        S_STAT_RD: begin
          if (dq_i[RDY_BIT]) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (tmo_q >= TMO_W'(TMO_CYC)) begin
            done_q     <= 1'b1;
            tmo_flag_q <= 1'b1;
            state_q    <= S_IDLE;
          end else begin
            state_q <= S_STAT_CMD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_pair.sv
module nand_ecc_pair #(
  parameter int unsigned NSEC  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  logic [31:0]      ecc_i,
  input  logic             spare_rd_i,
  input  logic [1:0]       spare_lane_i,
  input  logic [IDX_W-1:0] spare_idx_i,
  input  logic [7:0]       spare_dq_i,
  output logic             sec_valid_o,
  output logic [IDX_W-1:0] sec_idx_o,
  output logic [31:0]      sec_calc_o,
  output logic [31:0]      sec_stored_o
);
  logic [31:0] calc_q [NSEC];
  logic [23:0] sh_q;

  for (genvar g = 0; g < NSEC; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 calc_q[g] <= '0;
      else if (cap_i && cap_idx_i == IDX_W'(g))   calc_q[g] <= ecc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;  sec_valid_o <= 1'b0;  sec_idx_o <= '0;
      sec_calc_o <= '0;  sec_stored_o <= '0;
    end else begin
      sec_valid_o <= 1'b0;
      if (spare_rd_i) begin
        if (spare_lane_i == 2'd3) begin
          sec_valid_o  <= 1'b1;
          sec_idx_o    <= spare_idx_i;
          sec_calc_o   <= calc_q[spare_idx_i];
          sec_stored_o <= {spare_dq_i, sh_q};
        end else begin
          sh_q <= {spare_dq_i, sh_q[23:8]};
        end
      end
    end
  end
endmodule

// File: rtl/nand_page_rd.sv
module nand_page_rd #(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned ROW_W      = 24,
  parameter int unsigned RD_DLY     = 10,
  parameter int unsigned TWHR_DLY   = 6,
  parameter int unsigned TMO_CYC    = 100000
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      req_valid_i,
  input  logic [ROW_W-1:0]                          req_page_i,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]           req_len_i,
  output logic                                      req_ready_o,
  output logic                                      busy_o,
  output logic                                      nand_cle_o,
  output logic                                      nand_ale_o,
  output logic                                      nand_we_o,
  output logic                                      nand_re_o,
  output logic [7:0]                                nand_dq_o,
  input  logic [7:0]                                nand_dq_i,
  output logic                                      ecc_en_o,
  output logic                                      ecc_cap_o,
  input  logic [31:0]                               ecc_val_i,
  output logic                                      byte_valid_o,
  output logic [7:0]                                byte_o,
  output logic                                      sec_valid_o,
  output logic [$clog2(PAGE_BYTES/SECT_BYTES)-1:0]  sec_idx_o,
  output logic [31:0]                               sec_calc_o,
  output logic [31:0]                               sec_stored_o,
  output logic                                      done_o,
  output logic                                      timeout_o
);
  localparam int unsigned NSEC  = PAGE_BYTES / SECT_BYTES;
  localparam int unsigned LEN_W = $clog2(PAGE_BYTES + 1);
  localparam int unsigned IDX_W = $clog2(NSEC);

  logic             cap_w, spare_rd_w;
  logic [IDX_W-1:0] cap_idx_w, spare_idx_w;
  logic [1:0]       spare_lane_w;

  nand_rd_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .SECT_BYTES(SECT_BYTES), .ROW_W(ROW_W),
    .RD_DLY(RD_DLY), .TWHR_DLY(TWHR_DLY), .TMO_CYC(TMO_CYC),
    .LEN_W(LEN_W), .NSEC(NSEC), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_page_i, .req_len_i, .req_ready_o, .busy_o,
    .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_o(nand_we_o), .re_o(nand_re_o),
    .dq_o(nand_dq_o), .dq_i(nand_dq_i), .ecc_en_o, .ecc_cap_o(cap_w),
    .cap_idx_o(cap_idx_w), .spare_rd_o(spare_rd_w), .spare_lane_o(spare_lane_w),
    .spare_idx_o(spare_idx_w), .byte_valid_o, .byte_o, .done_o, .timeout_o
  );

  assign ecc_cap_o = cap_w;

  nand_ecc_pair #(.NSEC(NSEC), .IDX_W(IDX_W)) u_pair (
    .clk_i, .rst_ni, .cap_i(cap_w), .cap_idx_i(cap_idx_w), .ecc_i(ecc_val_i),
    .spare_rd_i(spare_rd_w), .spare_lane_i(spare_lane_w), .spare_idx_i(spare_idx_w),
    .spare_dq_i(nand_dq_i), .sec_valid_o, .sec_idx_o, .sec_calc_o, .sec_stored_o
  );
endmodule

// File: rtl/nand_page_rd_chk.sv
module nand_page_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_re_o,
  input logic ecc_en_o,
  input logic ecc_cap_o,
  input logic byte_valid_o,
  input logic sec_valid_o,
  input logic done_o,
  input logic timeout_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nand_cle_o, nand_ale_o, nand_re_o})); // R2
  AST_EN_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_en_o |-> nand_re_o); // R5
  AST_CAP_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_cap_o |-> !ecc_en_o && !nand_re_o && $past(ecc_en_o)); // R5
  AST_BYTE_AFTER_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(nand_re_o)); // R4
  AST_PAIR_AFTER_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_valid_o |-> $past(nand_re_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(nand_re_o)); // R9
  AST_TMO_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !nand_cle_o && !nand_ale_o && !nand_re_o); // R12
endmodule

bind nand_page_rd nand_page_rd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .nand_cle_o(nand_cle_o),
  .nand_ale_o(nand_ale_o), .nand_re_o(nand_re_o), .ecc_en_o(ecc_en_o),
  .ecc_cap_o(ecc_cap_o), .byte_valid_o(byte_valid_o), .sec_valid_o(sec_valid_o),
  .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/nand_page_rd_bench.sv
`timescale 1ns/1ps
module nand_page_rd_bench;
  localparam int PAGE = 32, SECT = 8, RDD = 3, TWH = 2, TMO = 40;
  localparam int NS = PAGE / SECT, LW = $clog2(PAGE + 1), IW = $clog2(NS);
  localparam int PER = 2 + TWH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_page = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, busy, cle, ale, we, re, ecc_en, ecc_cap, bv, sv, done, tmo;
  logic [7:0] dq_o, dq_i, byte_o;
  logic [31:0] ecc_val, calc_o, stored_o;
  logic [IW-1:0] sidx;

  always #10 clk = ~clk;

  nand_page_rd #(.PAGE_BYTES(PAGE), .SECT_BYTES(SECT), .ROW_W(24), .RD_DLY(RDD),
                 .TWHR_DLY(TWH), .TMO_CYC(TMO)) u_nand_page_rd (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_page_i(req_page),
    .req_len_i(req_len), .req_ready_o(req_ready), .busy_o(busy), .nand_cle_o(cle),
    .nand_ale_o(ale), .nand_we_o(we), .nand_re_o(re), .nand_dq_o(dq_o), .nand_dq_i(dq_i),
    .ecc_en_o(ecc_en), .ecc_cap_o(ecc_cap), .ecc_val_i(ecc_val), .byte_valid_o(bv),
    .byte_o(byte_o), .sec_valid_o(sv), .sec_idx_o(sidx), .sec_calc_o(calc_o),
    .sec_stored_o(stored_o), .done_o(done), .timeout_o(tmo)
  );

  int checks = 0, errors = 0;

  function automatic logic [7:0] dat(input logic [23:0] r, input int c);
    return 8'(int'(r) * 7 + c * 13 + 5);
  endfunction
  function automatic logic [31:0] stw(input logic [23:0] r, input int k);
    return {8'(k * 17 + 1), r} ^ 32'hA5C3_0000;
  endfunction

  // flash model
  logic [7:0]  m_cmd = 8'hFF;
  logic [15:0] m_col = '0;
  logic [23:0] m_row = '0;
  int m_an = 0, st_reads = 0, busy_cfg = 0;
  logic [31:0] acc = '0;

  always_comb begin
    if (m_cmd == 8'h70) dq_i = (st_reads >= busy_cfg) ? 8'hC1 : 8'hBF;
    else if (int'(m_col) < PAGE) dq_i = dat(m_row, int'(m_col));
    else dq_i = stw(m_row, (int'(m_col) - PAGE - 16) / 4)[8 * ((int'(m_col) - PAGE - 16) % 4) +: 8];
  end
  assign ecc_val = acc;

  always @(posedge clk) begin
    if (req_valid && req_ready) st_reads <= 0;
    if (cle) begin m_cmd <= dq_o; m_an <= 0; end
    if (ale) begin
      if (m_cmd == 8'h00) begin
        case (m_an)
          0: m_col[7:0] <= dq_o;  1: m_col[15:8] <= dq_o;
          2: m_row[7:0] <= dq_o;  3: m_row[15:8] <= dq_o;
          default: m_row[23:16] <= dq_o;
        endcase
      end else if (m_cmd == 8'h05) begin
        if (m_an == 0) m_col[7:0] <= dq_o; else m_col[15:8] <= dq_o;
      end
      m_an <= m_an + 1;
    end
    if (re) begin
      m_col <= m_col + 16'd1;
      if (m_cmd == 8'h70) st_reads <= st_reads + 1;
    end
    if (ecc_cap) acc <= '0;
    else if (re && ecc_en) acc <= acc + 32'(dq_i);
  end

  // recorder
  logic [12:0] got_q[$], exp_q[$];
  string tag_q[$];
  logic [7:0] gotb_q[$], expb_q[$];
  logic [IW+63:0] gots_q[$], exps_q[$];
  int cap_miss = 0, done_cnt = 0;
  logic tmo_last = 1'b0;

  always @(posedge clk) begin
    if (busy) got_q.push_back({cle, ale, re, ecc_en, ecc_cap,
                               (cle | ale) ? dq_o : (re ? dq_i : 8'h00)});
    if (bv) gotb_q.push_back(byte_o);
    if (sv) gots_q.push_back({sidx, calc_o, stored_o});
    if (ecc_cap && !bv) cap_miss++;
    if (done) begin done_cnt++; tmo_last = tmo; end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [4:0] k, input logic [7:0] v, input string tag);
    exp_q.push_back({k, v});
    tag_q.push_back(tag);
  endtask

  task automatic run_op(input logic [23:0] row, input int len, input int bcfg, input bit intrude);
    bit ecc_m = (len != 0) && (len % SECT == 0);
    int nsec = len / SECT, n = 0, d0, wd = 0, sz;
    bit exp_tmo = 0;
    logic [31:0] sum;
    got_q.delete(); exp_q.delete(); tag_q.delete();
    gotb_q.delete(); expb_q.delete(); gots_q.delete(); exps_q.delete();
    cap_miss = 0;
    busy_cfg = bcfg;
    if (len != 0) begin
      push(5'b10000, 8'h00, "R2");
      push(5'b01000, 8'h00, "R2"); push(5'b01000, 8'h00, "R2");
      push(5'b01000, row[7:0], "R2"); push(5'b01000, row[15:8], "R2");
      push(5'b01000, row[23:16], "R2");
      push(5'b10000, 8'h30, "R2");
      for (int i = 0; i < RDD; i++) push(5'b0, 8'h00, "R3");
      if (ecc_m) begin
        for (int s = 0; s < nsec; s++) begin
          sum = '0;
          for (int b = 0; b < SECT; b++) begin
            push(5'b00110, dat(row, s * SECT + b), "R5");
            expb_q.push_back(dat(row, s * SECT + b));
            sum += 32'(dat(row, s * SECT + b));
          end
          push(5'b00001, 8'h00, "R5");
          exps_q.push_back({IW'(s), sum, stw(row, s)});
        end
        push(5'b10000, 8'h05, "R7");
        push(5'b01000, 8'(PAGE + 16), "R7"); push(5'b01000, 8'((PAGE + 16) >> 8), "R7");
        push(5'b10000, 8'hE0, "R7");
        for (int i = 0; i < RDD; i++) push(5'b0, 8'h00, "R3");
        for (int k = 0; k < nsec; k++)
          for (int j = 0; j < 4; j++) push(5'b00100, stw(row, k)[8 * j +: 8], "R8");
      end else begin
        for (int c = 0; c < len; c++) begin
          push(5'b00100, dat(row, c), "R6");
          expb_q.push_back(dat(row, c));
        end
      end
    end
    forever begin
      push(5'b10000, 8'h70, (len == 0) ? "R11" : "R9");
      for (int i = 0; i < TWH; i++) push(5'b0, 8'h00, "R9");
      if (n >= bcfg) begin push(5'b00100, 8'hC1, "R9"); break; end
      push(5'b00100, 8'hBF, "R10");
      if (n * PER + PER - 1 >= TMO) begin exp_tmo = 1; break; end
      n++;
    end
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_page = row; req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_page = 24'h777777; req_len = LW'(5);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == d0 && wd < 5000) begin @(negedge clk); wd++; end
    chk(done_cnt != d0, "R9 done seen", 64'(done_cnt - d0), 64'd1);
    chk(got_q.size() == exp_q.size(), "R2 trace length", 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] === exp_q[i], $sformatf("%s trace cycle %0d", tag_q[i], i),
          64'(got_q[i]), 64'(exp_q[i]));
    chk(gotb_q.size() == expb_q.size(), "R4 byte count", 64'(gotb_q.size()), 64'(expb_q.size()));
    for (int i = 0; i < expb_q.size() && i < gotb_q.size(); i++)
      chk(gotb_q[i] === expb_q[i], "R4 stream byte", 64'(gotb_q[i]), 64'(expb_q[i]));
    chk(gots_q.size() == exps_q.size(), "R8 pair count", 64'(gots_q.size()), 64'(exps_q.size()));
    for (int i = 0; i < exps_q.size() && i < gots_q.size(); i++) begin
      chk(gots_q[i][63:0] === exps_q[i][63:0], "R8 calc/stored pair",
          gots_q[i][63:0], exps_q[i][63:0]);
      chk(gots_q[i][IW+63:64] === exps_q[i][IW+63:64], "R8 sector index",
          64'(gots_q[i][IW+63:64]), 64'(exps_q[i][IW+63:64]));
    end
    chk(cap_miss == 0, "R5 capture with last byte", 64'(cap_miss), 64'd0);
    chk(tmo_last === exp_tmo, "R10 timeout flag", 64'(tmo_last), 64'(exp_tmo));
    sz = got_q.size();
    repeat (10) @(negedge clk);
    chk(!busy && got_q.size() == sz, "R12 quiet after done", 64'(got_q.size()), 64'(sz));
    chk(tmo === exp_tmo, "R10 timeout held", 64'(tmo), 64'(exp_tmo));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, cle, ale, re, ecc_en, ecc_cap, bv, sv, done} == '0 && req_ready,
        "R1 reset outputs", 64'({busy, cle, ale, re, ecc_en, ecc_cap, bv, sv, done, req_ready}), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && req_ready && !done && !tmo, "R1 idle after reset", 64'(busy), 64'd0);
    run_op(24'h123456, PAGE, 0, 0);     // full page, R5 R7 R8
    run_op(24'h000000, SECT, 1, 1);     // one sector, request intrusion R12
    run_op(24'hABCDEF, 13, 0, 0);       // raw, R6
    run_op(24'h00FF01, 0, 2, 0);        // zero length, R11
    run_op(24'h5A5A5A, 2 * SECT, 3, 0); // busy polls, R9
    run_op(24'h0F0F0F, SECT, 1000000, 0); // never ready, R10
    run_op(24'hFEDCBA, 3 * SECT, 0, 0); // timeout flag cleared by next request
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule